// File: doc/BRIEF.md
# Recursive Quadrant Binary Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and presents their full `2*WIDTH`-bit product in the same cycle. It has no clock, no registers and no control inputs. `WIDTH` must be a power of two, at least 2. Typical values are 2, 4, 8 and 16.

The product is built by recursion, not by a partial-product array. Each operand is split into an upper and a lower half. Four half-width multipliers form the products low·low, low·high, high·low and high·high. A small adder network then lines these up at offsets of 0, `WIDTH/2` and `WIDTH` bits and adds them. The recursion stops at a 2-bit by 2-bit cell made of four AND gates and two half adders.

The adder network has three parts:
- two `WIDTH`-bit ripple adders, one for the two cross products and one that folds in the outer products;
- a half adder that merges the two carries left over from those adders;
- a `WIDTH/2`-bit adder that carries that merged value into the top of the product.

The lowest `WIDTH/2` bits of the low·low product go straight to the output without any addition.

Top module: `vedicMul`

## Requirements
- R1: For every pair of operand values, `product` equals the unsigned arithmetic product `opA*opB`, zero-extended to `2*WIDTH` bits.
- R2: With `WIDTH`=2, the base cell forms the product as follows. Bit 0 is `opA[0]&opB[0]`. Bit 1 is the XOR of the two cross terms `opA[0]&opB[1]` and `opA[1]&opB[0]`. Bits 3:2 are `opA[1]&opB[1]` plus the carry of those two cross terms. Every one of the 16 input pairs therefore yields the exact product.
- R3: The block is purely combinational: `product` reflects new operands within the same clock period, with no register in the path.
- R4: Bits `[WIDTH/2-1:0]` of `product` depend only on the lower halves of the operands. They equal the low `WIDTH/2` bits of (low half of `opA`) times (low half of `opB`), whatever the upper halves hold.
- R5: All-ones times all-ones gives exactly `2^(2*WIDTH) - 2^(WIDTH+1) + 1`, and the top-level carry out of the adder network is never set.
- R6: If either operand is zero, `product` is zero.
- R7: If one operand is 1, `product` equals the other operand.
- R8: Swapping the operands leaves `product` unchanged.
- R9: The same source gives exact products at `WIDTH` = 2, 4, 8 and 16. It checks at elaboration that `WIDTH` is a power of two of at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Unsigned multiplicand |
| opB | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned full-width product of opA and opB |

## Verification
Immediate assertions check several properties whenever the inputs settle:
- every recursion node, including each base cell, gives its exact local product;
- every ripple adder returns the exact sum of its inputs;
- the top carry of each quadrant adder network stays clear;
- the zero and unit-operand identities hold at the top.

Some behaviours appear only across several applied vectors, so only the bench's scenarios can show them:
- the independence of the low product bits from the upper operand halves;
- the symmetry under operand swap;
- settling within one period;
- the exhaustive sweep at widths 2 and 4.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  localparam int MIN_WIDTH = 2;

  function automatic bit isPowerOfTwo(input int value);
    return (value >= MIN_WIDTH) && ((value & (value - 1)) == 0);
  endfunction

endpackage

// File: rtl/vcmHalfAdd.sv
module vcmHalfAdd (
  input  logic inX,
  input  logic inY,
  output logic sum,
  output logic carry
);

  assign sum   = inX ^ inY;
  assign carry = inX & inY;

endmodule

// File: rtl/vcmRippleAdd.sv
module vcmRippleAdd #(
  parameter int W = 8
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut
);

  logic [W:0] chain;

  assign chain[0] = carryIn;

  for (genvar i = 0; i < W; i++) begin : gBit
    assign sum[i]     = addA[i] ^ addB[i] ^ chain[i];
    assign chain[i+1] = (addA[i] & addB[i]) | (chain[i] & (addA[i] ^ addB[i]));
  end

  assign carryOut = chain[W];

  always_comb begin
    AST_ADD_EXACT: assert ({carryOut, sum} == ({1'b0, addA} + {1'b0, addB} + (W+1)'(carryIn))) // R1
      else $error("ripple adder sum mismatch");
  end

endmodule

// File: rtl/vcmBaseCell.sv
module vcmBaseCell (
  input  logic [1:0] cellA,
  input  logic [1:0] cellB,
  output logic [3:0] cellProd
);

  logic termLoLo, termLoHi, termHiLo, termHiHi;
  logic crossSum, crossCarry, upperSum, upperCarry;

  assign termLoLo = cellA[0] & cellB[0];
  assign termLoHi = cellA[0] & cellB[1];
  assign termHiLo = cellA[1] & cellB[0];
  assign termHiHi = cellA[1] & cellB[1];

  vcmHalfAdd uCrossHa (
    .inX   (termLoHi),
    .inY   (termHiLo),
    .sum   (crossSum),
    .carry (crossCarry)
  );

  vcmHalfAdd uUpperHa (
    .inX   (termHiHi),
    .inY   (crossCarry),
    .sum   (upperSum),
    .carry (upperCarry)
  );

  assign cellProd = {upperCarry, upperSum, crossSum, termLoLo};

  always_comb begin
    AST_BASE_EXACT: assert (cellProd == ({2'b00, cellA} * {2'b00, cellB})) // R2
      else $error("base cell product mismatch");
  end

endmodule

// File: rtl/vcmQuadAdder.sv
module vcmQuadAdder #(
  parameter int N = 4
) (
  input  logic [N-1:0]   lowLow,
  input  logic [N-1:0]   lowHigh,
  input  logic [N-1:0]   highLow,
  input  logic [N-1:0]   highHigh,
  output logic [2*N-1:0] nodeProd
);

  localparam int HALF = N / 2;

  logic [N-1:0]    crossSum;
  logic            crossCarry;
  logic [N-1:0]    outerAddend;
  logic [N-1:0]    midSum;
  logic            midCarry;
  logic            spillSum;
  logic            spillCarry;
  logic [HALF-1:0] topAddend;
  logic [HALF-1:0] topSum;
  logic            topCarry;

  vcmRippleAdd #(.W(N)) uCrossAdd (
    .addA     (lowHigh),
    .addB     (highLow),
    .carryIn  (1'b0),
    .sum      (crossSum),
    .carryOut (crossCarry)
  );

  assign outerAddend = {highHigh[HALF-1:0], lowLow[N-1:HALF]};

  vcmRippleAdd #(.W(N)) uMidAdd (
    .addA     (crossSum),
    .addB     (outerAddend),
    .carryIn  (1'b0),
    .sum      (midSum),
    .carryOut (midCarry)
  );

  vcmHalfAdd uSpillHa (
    .inX   (crossCarry),
    .inY   (midCarry),
    .sum   (spillSum),
    .carry (spillCarry)
  );

  assign topAddend = HALF'({spillCarry, spillSum});

  vcmRippleAdd #(.W(HALF)) uTopAdd (
    .addA     (highHigh[N-1:HALF]),
    .addB     (topAddend),
    .carryIn  (1'b0),
    .sum      (topSum),
    .carryOut (topCarry)
  );

  assign nodeProd = {topSum, midSum, lowLow[HALF-1:0]};

  always_comb begin
    AST_NO_OVERFLOW: assert (topCarry == 1'b0) // R5
      else $error("quadrant adder top carry set");
  end

endmodule

// File: rtl/vcmMulNode.sv
module vcmMulNode #(
  parameter int N = 4
) (
  input  logic [N-1:0]   nodeA,
  input  logic [N-1:0]   nodeB,
  output logic [2*N-1:0] nodeProd
);

  localparam int HALF = N / 2;

  if (N == 2) begin : gLeaf
    vcmBaseCell uCell (
      .cellA    (nodeA),
      .cellB    (nodeB),
      .cellProd (nodeProd)
    );
  end else begin : gSplit
    logic [N-1:0] prodLL, prodLH, prodHL, prodHH;

    vcmMulNode #(.N(HALF)) uLL (
      .nodeA (nodeA[HALF-1:0]), .nodeB (nodeB[HALF-1:0]), .nodeProd (prodLL));
    vcmMulNode #(.N(HALF)) uLH (
      .nodeA (nodeA[HALF-1:0]), .nodeB (nodeB[N-1:HALF]), .nodeProd (prodLH));
    vcmMulNode #(.N(HALF)) uHL (
      .nodeA (nodeA[N-1:HALF]), .nodeB (nodeB[HALF-1:0]), .nodeProd (prodHL));
    vcmMulNode #(.N(HALF)) uHH (
      .nodeA (nodeA[N-1:HALF]), .nodeB (nodeB[N-1:HALF]), .nodeProd (prodHH));

    vcmQuadAdder #(.N(N)) uSum (
      .lowLow   (prodLL),
      .lowHigh  (prodLH),
      .highLow  (prodHL),
      .highHigh (prodHH),
      .nodeProd (nodeProd)
    );
  end

  always_comb begin
    AST_NODE_EXACT: assert (nodeProd == ({{N{1'b0}}, nodeA} * {{N{1'b0}}, nodeB})) // R1
      else $error("recursion node product mismatch");
  end

endmodule

// File: rtl/vedicMul.sv
module vedicMul #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);

  import vcm_pkg::*;

  localparam int PW = 2 * WIDTH;

  if (!isPowerOfTwo(WIDTH)) begin : gBadWidth
    $error("WIDTH must be a power of two and at least 2"); // R9
  end

  vcmMulNode #(.N(WIDTH)) uRoot (
    .nodeA    (opA),
    .nodeB    (opB),
    .nodeProd (product)
  );

  always_comb begin
    if (opA == '0 || opB == '0) begin
      AST_ZERO_ANNIHILATES: assert (product == '0) // R6
        else $error("zero operand gave nonzero product");
    end
    if (opB == WIDTH'(1)) begin
      AST_UNIT_IDENTITY: assert (product == PW'(opA)) // R7
        else $error("unit operand did not pass other operand");
    end
  end

endmodule

// File: tb/vedicMul_test.sv
module vedicMul_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]  a2 = '0, b2 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [3:0]  p2;
  logic [7:0]  p4;
  logic [15:0] p8;
  logic [31:0] p16;

  int checks = 0;
  int errors = 0;

  vedicMul #(.WIDTH(8))  uut        (.opA(a8),  .opB(b8),  .product(p8));
  vedicMul #(.WIDTH(2))  uutTwo     (.opA(a2),  .opB(b2),  .product(p2));
  vedicMul #(.WIDTH(4))  uutFour    (.opA(a4),  .opB(b4),  .product(p4));
  vedicMul #(.WIDTH(16)) uutSixteen (.opA(a16), .opB(b16), .product(p16));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns later, clear of any rising edge.
  task automatic apply(input logic [1:0] x2, input logic [1:0] y2,
                       input logic [3:0] x4, input logic [3:0] y4,
                       input logic [7:0] x8, input logic [7:0] y8,
                       input logic [15:0] x16, input logic [15:0] y16);
    @(negedge clk);
    a2 = x2; b2 = y2; a4 = x4; b4 = y4;
    a8 = x8; b8 = y8; a16 = x16; b16 = y16;
    #1;
  endtask

  task automatic checkAll(input string req);
    check({req, " w2"},  longint'(p2),  longint'(a2)  * longint'(b2));
    check({req, " w4"},  longint'(p4),  longint'(a4)  * longint'(b4));
    check({req, " w8"},  longint'(p8),  longint'(a8)  * longint'(b8));
    check({req, " w16"}, longint'(p16), longint'(a16) * longint'(b16));
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r16a, r16b;
    logic [7:0]  r8a, r8b;
    longint      first8, first16;

    // Idle state: zero operands everywhere (R6)
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    check("R6 idle w8", longint'(p8), 0);
    check("R6 idle w16", longint'(p16), 0);

    // Exhaustive sweeps at widths 2 and 4, random at 8 and 16 (R1, R2, R9)
    for (int i = 0; i < 256; i++) begin
      apply(i[3:2], i[1:0], i[7:4], i[3:0], 8'($urandom), 8'($urandom),
            16'($urandom), 16'($urandom));
      check("R2 base cell", longint'(p2), longint'(a2) * longint'(b2));
      checkAll("R1 R9 sweep");
    end

    // Random at 8 and 16 (R1)
    for (int i = 0; i < 1500; i++) begin
      apply(2'($urandom), 2'($urandom), 4'($urandom), 4'($urandom),
            8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
      checkAll("R1 random");
    end

    // All-ones squared (R5)
    apply('1, '1, '1, '1, '1, '1, '1, '1);
    check("R5 w2",  longint'(p2),  longint'(16 - 8 + 1));
    check("R5 w4",  longint'(p4),  longint'(256 - 32 + 1));
    check("R5 w8",  longint'(p8),  longint'(65536 - 512 + 1));
    check("R5 w16", longint'(p16), (longint'(1) << 32) - (longint'(1) << 17) + 1);

    // Zero with all-ones (R6)
    apply(0, '1, '1, 0, 0, '1, '1, 0);
    check("R6 w2",  longint'(p2),  0);
    check("R6 w4",  longint'(p4),  0);
    check("R6 w8",  longint'(p8),  0);
    check("R6 w16", longint'(p16), 0);

    // Unit operand (R7)
    apply(2'd3, 2'd1, 4'hB, 4'd1, 8'hA7, 8'd1, 16'hC35A, 16'd1);
    check("R7 w2",  longint'(p2),  3);
    check("R7 w4",  longint'(p4),  'hB);
    check("R7 w8",  longint'(p8),  'hA7);
    check("R7 w16", longint'(p16), 'hC35A);

    // Top bit only and alternating patterns (R1)
    apply(2'b10, 2'b10, 4'h8, 4'h8, 8'h80, 8'h80, 16'h8000, 16'h8000);
    check("R1 msb w8",  longint'(p8),  'h4000);
    check("R1 msb w16", longint'(p16), 'h4000_0000);
    apply(2'b01, 2'b10, 4'h5, 4'hA, 8'h55, 8'hAA, 16'h5555, 16'hAAAA);
    checkAll("R1 alternating");

    // Operand swap gives the same product (R8)
    for (int i = 0; i < 20; i++) begin
      r8a = 8'($urandom); r8b = 8'($urandom);
      r16a = 16'($urandom); r16b = 16'($urandom);
      apply(0, 0, 0, 0, r8a, r8b, r16a, r16b);
      first8 = longint'(p8); first16 = longint'(p16);
      apply(0, 0, 0, 0, r8b, r8a, r16b, r16a);
      check("R8 swap w8",  longint'(p8),  first8);
      check("R8 swap w16", longint'(p16), first16);
    end

    // Low product bits ignore the upper operand halves (R4)
    for (int i = 0; i < 16; i++) begin
      apply(0, 0, 0, 0, {4'(i), 4'hD}, {4'($urandom), 4'h7},
            {8'($urandom), 8'hE3}, {8'(i * 17), 8'h9B});
      check("R4 low bits w8",  longint'(p8[3:0]),  longint'(8'(8'hD * 8'h7) & 8'hF));
      check("R4 low bits w16", longint'(p16[7:0]), longint'(16'(16'hE3 * 16'h9B) & 16'hFF));
    end

    // New operands settle within one period, no clock edge involved (R3)
    @(posedge clk);
    #1;
    a8 = 8'd200; b8 = 8'd250; a16 = 16'd60000; b16 = 16'd3;
    #0.5;
    check("R3 same period w8",  longint'(p8),  50000);
    check("R3 same period w16", longint'(p16), 180000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule